// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It takes the memory from power-on to a usable state, then keeps the stored data alive. Straight after reset it holds the device quiet for a long settling time. It then closes every bank, runs a fixed number of auto-refresh cycles and writes the mode register with a value supplied by the surrounding controller. After the last wait it raises `ready`, which stays high until the next reset.

From then on an interval timer tracks how much refresh work is owed. Each time the interval runs out, one refresh is added to a small debt counter, which saturates at a parameterised limit. `ref_req` is high while the debt is not zero. An external arbiter answers with `ref_grant`. The sequencer issues one auto-refresh per grant it accepts and then waits out the refresh cycle time before it accepts another.

Every timing value is given in nanoseconds together with the clock frequency in MHz. Each value is turned into a cycle count that is rounded up, so no minimum is ever cut short.

Top module: `sdr_bringup_seq`

## Requirements
- R1: From reset until the first precharge, `cke` and `dqm` are high and the command pins {cs_n,ras_n,cas_n,we_n} carry NOP (4'b0111) for at least ceil(PWRUP_NS*CLK_MHZ/1000) cycles after reset release; `ready` is low during reset.
- R2: The first non-NOP command is precharge (4'b0010) with address bit 10 high, selecting all banks.
- R3: Every wait is at least the rounded-up cycle count of its minimum. Precharge to first refresh is at least tRP. Each refresh to the next command is at least tRFC. Mode set to `ready` is at least tRSC, with only NOP in between.
- R4: Exactly INIT_REFS auto-refresh commands (4'b0001) follow the precharge, then one mode set (4'b0000) that drives `mode_cfg` on `addr` and zero on `ba`.
- R5: `ready` rises once after the mode-set wait and stays high until reset.
- R6: `ref_req` first rises between REFI and REFI+1 cycles after `ready`, where REFI = ceil(REFI_NS*CLK_MHZ/1000). While `ref_grant` is low, no refresh is issued and the request stays high.
- R7: At most MAX_OWED intervals are queued. After a long stall, holding the grant high drains between MAX_OWED and MAX_OWED+1 refreshes before `ref_req` falls; the extra one covers an interval that runs out during the drain.
- R8: A refresh in normal operation is issued only in the cycle after `ref_req` and `ref_grant` are both seen high, and back-to-back refreshes are at least tRFC apart.
- R9: `cas_lat_bad` is updated when the mode set is issued. It is 1 when the latency field `mode_cfg[6:4]` holds a code other than 2 or 3, and 0 otherwise. Burst length is in [2:0], burst type in [3] and write mode in [9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | AW | Value written into the mode register |
| ref_grant | input | 1 | Arbiter permission to issue a pending refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| dqm | output | 1 | Data mask, held high |
| ba | output | 2 | Bank address, driven zero |
| addr | output | AW | Address bus |
| ready | output | 1 | Bring-up complete |
| ref_req | output | 1 | At least one refresh is owed |
| cas_lat_bad | output | 1 | Programmed latency code is unsupported |

## Verification
Two events can land in the same cycle: an interval running out, which adds one to the debt, and a granted refresh, which takes one away. When both happen together the debt must stay level, so that no refresh is lost and none is counted twice. The bench sets this up by letting the debt saturate while the grant is low, then holding the grant high. An interval expiry can then land inside the drain. The bench judges the outcome by the total number of refreshes drained and by their spacing.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_PWR,
    ST_RP,
    ST_IREF,
    ST_RSC,
    ST_IDLE,
    ST_RFC
  } seq_st_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R3: a non-zero wait never ends in the cycle right after it starts
  p_wait_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !done);

endmodule

// File: rtl/sdr_refresh_tracker.sv
module sdr_refresh_tracker #(
  parameter int REFI_CYC = 780,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic consume,
  output logic ref_req
);

  localparam int IW = $clog2(REFI_CYC + 1);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [IW-1:0] IV_LOAD = IW'(REFI_CYC - 1);
  localparam logic [OW-1:0] OWED_CAP = OW'(MAX_OWED);

  logic [IW-1:0] ivl_q, ivl_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick;

  always_comb begin
    tick  = run && (ivl_q == '0);
    ivl_d = ivl_q;
    if (!run || ivl_q == '0) ivl_d = IV_LOAD;
    else                     ivl_d = ivl_q - 1'b1;

    owed_d = owed_q;
    case ({tick, consume})
      2'b10:   if (owed_q != OWED_CAP) owed_d = owed_q + 1'b1;
      2'b01:   owed_d = owed_q - 1'b1;
      default: owed_d = owed_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= IV_LOAD;
      owed_q <= '0;
    end else begin
      ivl_q  <= ivl_d;
      owed_q <= owed_d;
    end
  end

  assign ref_req = (owed_q != '0);

  // R7: debt never exceeds the queue limit
  p_owed_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OWED_CAP);
  // R8: a refresh is only consumed while one is owed
  p_consume_debt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> ref_req);
  // R6: a new request only appears after an interval expiry
  p_req_from_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req) |-> $past(tick));

endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq
  import sdr_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PWRUP_NS  = 100000,
  parameter int TRP_NS    = 20,
  parameter int TRFC_NS   = 80,
  parameter int TRSC_NS   = 20,
  parameter int REFI_NS   = 7800,
  parameter int INIT_REFS = 2,
  parameter int MAX_OWED  = 8,
  parameter int AW        = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mode_cfg,
  input  logic          ref_grant,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          cke,
  output logic          dqm,
  output logic [1:0]    ba,
  output logic [AW-1:0] addr,
  output logic          ready,
  output logic          ref_req,
  output logic          cas_lat_bad
);

  localparam int PWR_CYC  = ns_to_cyc(PWRUP_NS, CLK_MHZ);
  localparam int TRP_CYC  = ns_to_cyc(TRP_NS, CLK_MHZ);
  localparam int TRFC_CYC = ns_to_cyc(TRFC_NS, CLK_MHZ);
  localparam int TRSC_CYC = ns_to_cyc(TRSC_NS, CLK_MHZ);
  localparam int REFI_CYC = ns_to_cyc(REFI_NS, CLK_MHZ);
  localparam int MAXW     = max2(max2(PWR_CYC, TRP_CYC), max2(TRFC_CYC, TRSC_CYC));
  localparam int TW       = $clog2(MAXW + 1);
  localparam int RW       = $clog2(INIT_REFS + 1);
  localparam int ALL_BANK_BIT = 10;
  localparam int CL_LSB   = 4;

  seq_st_e       st_q, st_d;
  sdr_cmd_e      cmd_q, cmd_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          ready_q, ready_d;
  logic          bad_q, bad_d;
  logic [RW-1:0] refs_q, refs_d;
  logic          tm_load, tm_done, consume;
  logic [TW-1:0] tm_val;
  logic [2:0]    cl_code;

  assign cl_code = mode_cfg[CL_LSB +: 3];

  sdr_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .done(tm_done)
  );

  sdr_refresh_tracker #(.REFI_CYC(REFI_CYC), .MAX_OWED(MAX_OWED)) u_track (
    .clk(clk), .rst_n(rst_n), .run(ready_q), .consume(consume), .ref_req(ref_req)
  );

  always_comb begin
    st_d    = st_q;
    cmd_d   = CMD_NOP;
    addr_d  = '0;
    ready_d = ready_q;
    bad_d   = bad_q;
    refs_d  = refs_q;
    tm_load = 1'b0;
    tm_val  = '0;
    consume = 1'b0;
    case (st_q)
      ST_BOOT: begin
        tm_load = 1'b1;
        tm_val  = TW'(PWR_CYC - 1);
        st_d    = ST_PWR;
      end
      ST_PWR: if (tm_done) begin
        cmd_d = CMD_PRE;
        addr_d[ALL_BANK_BIT] = 1'b1;
        tm_load = 1'b1;
        tm_val  = TW'(TRP_CYC - 1);
        st_d    = ST_RP;
      end
      ST_RP: if (tm_done) begin
        cmd_d   = CMD_REF;
        tm_load = 1'b1;
        tm_val  = TW'(TRFC_CYC - 1);
        refs_d  = RW'(INIT_REFS - 1);
        st_d    = ST_IREF;
      end
      ST_IREF: if (tm_done) begin
        tm_load = 1'b1;
        if (refs_q != '0) begin
          cmd_d  = CMD_REF;
          tm_val = TW'(TRFC_CYC - 1);
          refs_d = refs_q - 1'b1;
        end else begin
          cmd_d  = CMD_MRS;
          addr_d = mode_cfg;
          tm_val = TW'(TRSC_CYC - 1);
          bad_d  = !(cl_code == 3'd2 || cl_code == 3'd3);
          st_d   = ST_RSC;
        end
      end
      ST_RSC: if (tm_done) begin
        ready_d = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_IDLE: if (ref_req && ref_grant) begin
        cmd_d   = CMD_REF;
        tm_load = 1'b1;
        tm_val  = TW'(TRFC_CYC - 1);
        consume = 1'b1;
        st_d    = ST_RFC;
      end
      ST_RFC: if (tm_done) st_d = ST_IDLE;
      default: st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_BOOT;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ready_q <= 1'b0;
      bad_q   <= 1'b0;
      refs_q  <= '0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      ready_q <= ready_d;
      bad_q   <= bad_d;
      refs_q  <= refs_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr        = addr_q;
  assign ba          = 2'b00;
  assign cke         = 1'b1;
  assign dqm         = 1'b1;
  assign ready       = ready_q;
  assign cas_lat_bad = bad_q;

  // R2: precharge always selects every bank
  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> addr_q[ALL_BANK_BIT]);
  // R4: mode set carries the configured value
  p_mrs_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |-> (addr_q == $past(mode_cfg)));
  // R5: ready never drops once raised
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);
  // R8: normal-mode refresh follows a grant
  p_ref_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && cmd_q == CMD_REF) |-> ($past(ref_grant) && $past(ref_req)));

endmodule

// File: tb/sim_sdr_bringup_seq.sv
`timescale 1ns/1ps
module sim_sdr_bringup_seq;

  localparam int MHZ = 50, P_PWR = 2000, P_RP = 20, P_RFC = 70, P_RSC = 20, P_REFI = 400;
  localparam int NREF = 2, QMAX = 3;
  localparam int E_PWR  = (P_PWR  * MHZ + 999) / 1000;
  localparam int E_TRP  = (P_RP   * MHZ + 999) / 1000;
  localparam int E_TRFC = (P_RFC  * MHZ + 999) / 1000;
  localparam int E_TRSC = (P_RSC  * MHZ + 999) / 1000;
  localparam int E_REFI = (P_REFI * MHZ + 999) / 1000;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam logic [3:0] EXP_CODE [4] = '{PRE, REF, REF, MRS};
  localparam int         EXP_GAP  [4] = '{E_PWR, E_TRP, E_TRFC, E_TRFC};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, ref_grant;
  logic [12:0] mode_cfg;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm, ready, ref_req, cas_lat_bad;
  logic [1:0]  ba;
  logic [12:0] addr;
  wire  [3:0]  cmd = {cs_n, ras_n, cas_n, we_n};

  sdr_bringup_seq #(
    .CLK_MHZ(MHZ), .PWRUP_NS(P_PWR), .TRP_NS(P_RP), .TRFC_NS(P_RFC), .TRSC_NS(P_RSC),
    .REFI_NS(P_REFI), .INIT_REFS(NREF), .MAX_OWED(QMAX), .AW(13)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .ref_grant(ref_grant),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .dqm(dqm),
    .ba(ba), .addr(addr), .ready(ready), .ref_req(ref_req), .cas_lat_bad(cas_lat_bad)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [12:0] mode_word(input logic [2:0] cl);
    return {3'b000, 1'b0, 2'b00, cl, 1'b0, 3'b011};
  endfunction

  task automatic wait_cmd(output logic [3:0] c, output int gap, output bit pins_ok);
    gap = 0;
    pins_ok = 1'b1;
    do begin
      @(negedge clk);
      gap++;
      if (!(cke && dqm)) pins_ok = 1'b0;
    end while (cmd == NOP && gap < 1000);
    c = cmd;
  endtask

  task automatic run_init(input logic [2:0] cl);
    logic [3:0] c;
    int gap, g;
    bit pok, stray;
    mode_cfg  = mode_word(cl);
    ref_grant = 1'b0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd == NOP, "R1 reset NOP", cmd, NOP);
    chk(cke && dqm, "R1 reset cke/dqm", {cke, dqm}, 3);
    chk(!ready, "R1 ready low in reset", ready, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_cmd(c, gap, pok);
      chk(c == EXP_CODE[i], (i == 0) ? "R2 first command" : "R4 command order", c, EXP_CODE[i]);
      chk(gap >= EXP_GAP[i], (i == 0) ? "R1 power-up wait" : "R3 step wait", gap, EXP_GAP[i]);
      if (i == 0) begin
        chk(pok, "R1 cke/dqm during wait", pok, 1);
        chk(addr[10], "R2 all-bank bit", addr[10], 1);
      end
      if (i == 3) chk(addr == mode_word(cl) && ba == 2'b00, "R4 mode value", addr, mode_word(cl));
    end
    g = 0;
    stray = 1'b0;
    while (!ready && g < 1000) begin
      @(negedge clk);
      g++;
      if (cmd != NOP) stray = 1'b1;
    end
    chk(g >= E_TRSC && !stray, "R3 mode-set to ready", g, E_TRSC);
    chk(cas_lat_bad == !(cl == 3'd2 || cl == 3'd3), "R9 latency flag", cas_lat_bad,
        !(cl == 3'd2 || cl == 3'd3));
  endtask

  initial begin
    int g, n, t, last, mingap;
    bit rdy_ok;
    rst_n = 1'b0;
    ref_grant = 1'b0;
    mode_cfg = '0;

    run_init(3'd2);

    // R6: first request timing
    g = 0;
    while (!ref_req && g < 200) begin
      @(negedge clk);
      g++;
    end
    chk(g >= E_REFI && g <= E_REFI + 1, "R6 first request delay", g, E_REFI);

    // R6: no refresh without grant
    n = 0;
    rdy_ok = 1'b1;
    repeat (5 * E_REFI) begin
      @(negedge clk);
      if (cmd == REF) n++;
      if (!ready) rdy_ok = 1'b0;
    end
    chk(n == 0, "R6 refresh without grant", n, 0);
    chk(ref_req, "R6 request held", ref_req, 1);

    // R7/R8: drain saturated queue with grant held
    ref_grant = 1'b1;
    n = 0; t = 0; last = 0; mingap = 1000;
    while (ref_req && t < 500) begin
      @(negedge clk);
      t++;
      if (cmd == REF) begin
        n++;
        if (n > 1 && (t - last) < mingap) mingap = t - last;
        last = t;
      end
      if (!ready) rdy_ok = 1'b0;
    end
    ref_grant = 1'b0;
    chk(n >= QMAX && n <= QMAX + 1, "R7 queued refreshes drained", n, QMAX);
    chk(mingap >= E_TRFC, "R8 refresh spacing", mingap, E_TRFC);

    // R8: grant response
    repeat (E_TRFC + 2) @(negedge clk);
    g = 0;
    while (!ref_req && g < 200) begin
      @(negedge clk);
      g++;
    end
    n = 0;
    repeat (3) begin
      @(negedge clk);
      if (cmd == REF) n++;
    end
    chk(n == 0, "R8 no refresh before grant", n, 0);
    ref_grant = 1'b1;
    @(negedge clk);
    chk(cmd == REF, "R8 refresh after grant", cmd, REF);
    ref_grant = 1'b0;
    @(negedge clk);
    chk(rdy_ok && ready, "R5 ready held", ready, 1);

    // R9: other latency codes
    run_init(3'd3);
    run_init(3'd5);
    run_init(3'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule